// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Carry, Overflow and Condition Flags

This block is the adder lane of a RISC execute stage. It accepts two 64-bit operands, a 16-bit immediate, an incoming carry and an incoming summary-overflow bit. A 3-bit operation code selects one of eight add or subtract forms. Two qualifiers go with the code. One enables overflow reporting. The other requests record form, which produces a 4-bit condition field.

The sum is formed in one cycle by a carry chain split into 32-bit segments. Carry and overflow are taken at both the 32-bit and the 64-bit boundary. The result and all flags are captured in an output register stage. Each flag group leaves with its own write enable, so writeback can update only the flags the operation defines.

Instruction decode, register file access and writeback arbitration sit outside this block. The caller provides a `ra_zero` qualifier when the source register index is 0.

Top module: `int_addsub_unit`

## Requirements
- R1: Operation codes are ADD=0 (A+B), ADDE=2 (A+B+carry-in), ADDM1=3 (A plus all-ones plus carry-in), ADDZ=4 (A+carry-in), ADDI=5 (A plus the sign-extended immediate) and ADDIH=6 (A plus the sign-extended immediate shifted left by 16). All results are truncated to 64 bits.
- R2: SUBF=1 yields (NOT A)+B+1 and SUBFI=7 yields (NOT A)+sign-extended immediate+1, both truncated to 64 bits.
- R3: For ADDI and ADDIH, `ra_zero`=1 replaces operand A with zero. For every other code, `ra_zero` has no effect.
- R4: `ca_out[0]` is the carry out of bit 63 of the full sum. `ca_out[1]` is the carry out of bit 31 of the low-half sum, including the carry-in. `ca_we` is 1 only for ADDE, ADDM1, ADDZ and SUBFI. When `ca_we` is 0, `ca_out` is 0.
- R5: At each boundary, overflow is (carry at that boundary XOR result top bit there) AND NOT (effective A XOR effective B at that top bit). `ov_out[0]` is the 64-bit overflow and `ov_out[1]` the 32-bit overflow. `ov_we` = `ov_en` AND code in 0..4. When `ov_we` is 0, `ov_out` is 0.
- R6: `so_out` = `so_in` OR (`ov_we` AND 64-bit overflow). It never clears a set `so_in`.
- R7: `cr_we` = `rec_en` AND code in 0..4. When `cr_we` is 1, `cr_out` holds {negative, positive nonzero, zero, `so_out`} in bits 3..0. Otherwise `cr_out` is 0.
- R8: `out_valid` is `in_valid` delayed by one clock. With `in_valid` low, all result and flag outputs hold their values.
- R9: An active-low asynchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 3 | Operation code (see R1, R2) |
| ov_en | input | 1 | Overflow-enabled form |
| rec_en | input | 1 | Record form, writes condition field |
| ra_zero | input | 1 | Source index is 0 (immediate-add forms) |
| opnd_a | input | 64 | Operand A |
| opnd_b | input | 64 | Operand B |
| imm | input | 16 | Signed immediate |
| ca_in | input | 1 | Incoming carry |
| so_in | input | 1 | Incoming summary overflow |
| out_valid | output | 1 | Registered result valid |
| result | output | 64 | Sum |
| ca_out | output | 2 | {carry at 32, carry at 64} |
| ca_we | output | 1 | Carry write enable |
| ov_out | output | 2 | {overflow at 32, overflow at 64} |
| ov_we | output | 1 | Overflow/summary write enable |
| so_out | output | 1 | Summary overflow |
| cr_out | output | 4 | Condition nibble |
| cr_we | output | 1 | Condition write enable |

## Verification
The bench targets the following corner cases:
- Overflow at exactly one boundary: 0x7FFFFFFF+1 sets only the 32-bit flag. A design that swaps or shares the boundaries would flag both or neither.
- Add-minus-one with carry-in 1 must return A unchanged with both carries set. Dropping the carry-in gives A-1.
- Add-minus-one from the most negative value overflows. Using raw instead of effective operands in the overflow term would miss it.
- A set incoming summary bit with no overflow must still reach bit 0 of the condition nibble. A design that drops it reports a clean field.
- An immediate-shifted add with `ra_zero` must ignore a nonzero A.
- Overflow inputs on non-overflow forms must not raise any flag.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUBF  = 3'd1,
    OP_ADDE  = 3'd2,
    OP_ADDM1 = 3'd3,
    OP_ADDZ  = 3'd4,
    OP_ADDI  = 3'd5,
    OP_ADDIH = 3'd6,
    OP_SUBFI = 3'd7
  } addsub_op_e;

  // register-register forms: carry overflow and record qualifiers
  function automatic logic op_has_ov(addsub_op_e op);
    return (op == OP_ADD) || (op == OP_SUBF) || (op == OP_ADDE) ||
           (op == OP_ADDM1) || (op == OP_ADDZ);
  endfunction

  function automatic logic op_sets_carry(addsub_op_e op);
    return (op == OP_ADDE) || (op == OP_ADDM1) || (op == OP_ADDZ) ||
           (op == OP_SUBFI);
  endfunction

endpackage

// File: rtl/addsub_opnd_sel.sv
module addsub_opnd_sel
  import addsub_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 16
) (
  input  addsub_op_e        op,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  input  logic [IMMW-1:0]   imm,
  input  logic              ra_zero,
  input  logic              ca_in,
  output logic [XLEN-1:0]   a_eff,
  output logic [XLEN-1:0]   b_eff,
  output logic              cin
);

  logic [XLEN-1:0] imm_sx;
  logic [XLEN-1:0] imm_hi;
  logic [XLEN-1:0] a_base;

  always_comb begin
    imm_sx = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
    imm_hi = imm_sx << IMMW;
    a_base = ra_zero ? '0 : a;
    a_eff  = a;
    b_eff  = b;
    cin    = 1'b0;
    unique case (op)
      OP_ADD:   begin a_eff = a;      b_eff = b;      cin = 1'b0;  end
      OP_SUBF:  begin a_eff = ~a;     b_eff = b;      cin = 1'b1;  end
      OP_ADDE:  begin a_eff = a;      b_eff = b;      cin = ca_in; end
      OP_ADDM1: begin a_eff = a;      b_eff = '1;     cin = ca_in; end
      OP_ADDZ:  begin a_eff = a;      b_eff = '0;     cin = ca_in; end
      OP_ADDI:  begin a_eff = a_base; b_eff = imm_sx; cin = 1'b0;  end
      OP_ADDIH: begin a_eff = a_base; b_eff = imm_hi; cin = 1'b0;  end
      OP_SUBFI: begin a_eff = ~a;     b_eff = imm_sx; cin = 1'b1;  end
      default:  begin a_eff = a;      b_eff = b;      cin = 1'b0;  end
    endcase
  end

endmodule

// File: rtl/addsub_seg_adder.sv
module addsub_seg_adder #(
  parameter int XLEN  = 64,
  parameter int SEG_W = 32
) (
  input  logic [XLEN-1:0]            a_eff,
  input  logic [XLEN-1:0]            b_eff,
  input  logic                       cin,
  output logic [XLEN-1:0]            sum,
  output logic [(XLEN/SEG_W)-1:0]    carry_seg,
  output logic [(XLEN/SEG_W)-1:0]    ovf_seg
);

  localparam int NSEG = XLEN / SEG_W;

  logic [NSEG:0] cy;
  assign cy[0] = cin;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic [SEG_W:0] part;
    assign part = {1'b0, a_eff[g*SEG_W +: SEG_W]} +
                  {1'b0, b_eff[g*SEG_W +: SEG_W]} +
                  {{SEG_W{1'b0}}, cy[g]};
    assign sum[g*SEG_W +: SEG_W] = part[SEG_W-1:0];
    assign cy[g+1]      = part[SEG_W];
    assign carry_seg[g] = part[SEG_W];
    // signed overflow of everything below this boundary
    assign ovf_seg[g] = (part[SEG_W] ^ part[SEG_W-1]) &
                        ~(a_eff[(g+1)*SEG_W-1] ^ b_eff[(g+1)*SEG_W-1]);
  end

endmodule

// File: rtl/addsub_cond_nibble.sv
module addsub_cond_nibble #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] sum,
  input  logic            so_bit,
  input  logic            rec_on,
  output logic [3:0]      nib
);

  logic neg, zero, pos;

  always_comb begin
    neg  = sum[XLEN-1];
    zero = (sum == '0);
    pos  = ~neg & ~zero;
    nib  = rec_on ? {neg, pos, zero, so_bit} : 4'b0000;
  end

  // R7
  always_comb begin
    if (rec_on) begin
      cond_onehot_chk: assert ($onehot({nib[3], nib[2], nib[1]}));
    end
  end

endmodule

// File: rtl/int_addsub_unit.sv
module int_addsub_unit
  import addsub_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int SEG_W = 32,
  parameter int IMMW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2:0]      op_sel,
  input  logic            ov_en,
  input  logic            rec_en,
  input  logic            ra_zero,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  logic [IMMW-1:0] imm,
  input  logic            ca_in,
  input  logic            so_in,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic [1:0]      ca_out,
  output logic            ca_we,
  output logic [1:0]      ov_out,
  output logic            ov_we,
  output logic            so_out,
  output logic [3:0]      cr_out,
  output logic            cr_we
);

  localparam int NSEG = XLEN / SEG_W;

  addsub_op_e        op;
  logic [XLEN-1:0]   a_eff, b_eff, sum;
  logic              cin;
  logic [NSEG-1:0]   carry_seg, ovf_seg;

  logic              ca_we_n, ov_we_n, cr_we_n, so_n;
  logic [1:0]        ca_n, ov_n;
  logic [3:0]        cr_n;

  assign op = addsub_op_e'(op_sel);

  addsub_opnd_sel #(.XLEN(XLEN), .IMMW(IMMW)) u_opnd (
    .op(op), .a(opnd_a), .b(opnd_b), .imm(imm), .ra_zero(ra_zero),
    .ca_in(ca_in), .a_eff(a_eff), .b_eff(b_eff), .cin(cin)
  );

  addsub_seg_adder #(.XLEN(XLEN), .SEG_W(SEG_W)) u_add (
    .a_eff(a_eff), .b_eff(b_eff), .cin(cin), .sum(sum),
    .carry_seg(carry_seg), .ovf_seg(ovf_seg)
  );

  // next-state flag selection
  always_comb begin
    ca_we_n = op_sets_carry(op);
    ov_we_n = ov_en & op_has_ov(op);
    cr_we_n = rec_en & op_has_ov(op);
    ca_n    = ca_we_n ? {carry_seg[0], carry_seg[NSEG-1]} : 2'b00;
    ov_n    = ov_we_n ? {ovf_seg[0], ovf_seg[NSEG-1]} : 2'b00;
    so_n    = so_in | (ov_we_n & ovf_seg[NSEG-1]);
  end

  addsub_cond_nibble #(.XLEN(XLEN)) u_cond (
    .sum(sum), .so_bit(so_n), .rec_on(cr_we_n), .nib(cr_n)
  );

  // valid register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  // data registers, clock-enabled by in_valid
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      ca_out <= 2'b00;
      ca_we  <= 1'b0;
      ov_out <= 2'b00;
      ov_we  <= 1'b0;
      so_out <= 1'b0;
      cr_out <= 4'b0000;
      cr_we  <= 1'b0;
    end else if (in_valid) begin
      result <= sum;
      ca_out <= ca_n;
      ca_we  <= ca_we_n;
      ov_out <= ov_n;
      ov_we  <= ov_we_n;
      so_out <= so_n;
      cr_out <= cr_n;
      cr_we  <= cr_we_n;
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(cr_out)));
  // R5
  ov_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ov_we |-> (ov_out == 2'b00));
  // R6
  so_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && so_in) |=> so_out);
  // R7
  cr_so_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> (cr_out[0] == so_out));
  // R4
  addz_nocarry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd4 && !ca_in) |=> (ca_out == 2'b00));

endmodule

// File: tb/int_addsub_unit_bench.sv
module int_addsub_unit_bench;

  localparam int CLK_P = 10;
  localparam int NV    = 20;

  // vector: op[215:213] oe[212] rc[211] az[210] ca[209] so[208]
  //         a[207:144] b[143:80] imm[79:64] expected result[63:0]
  localparam logic [215:0] VEC [NV] = '{
    {3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,64'hc523e996a8ff6215,64'he1e5b9cc9864c4a8,16'h0000,64'ha709a363416426bd},
    {3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,64'h3d7f3f7ca24bac7b,64'hf6b2ac5e13ee15c2,16'h0000,64'hb9336ce171a26947},
    {3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,64'h833652d96c7c0058,64'h1c27ecff8a086c1a,16'h0000,64'h98f19a261d8c6bc2},
    {3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,64'h2e08ae202742baf8,64'h86c43ece9efe5baa,16'h0000,64'hb4cceceec64116a2},
    {3'd3,1'b1,1'b0,1'b0,1'b0,1'b0,64'h00000007ffffffff,64'h0,16'h0000,64'h00000007fffffffe},
    {3'd3,1'b1,1'b1,1'b0,1'b1,1'b0,64'h00000007ffffffff,64'h0,16'h0000,64'h00000007ffffffff},
    {3'd3,1'b0,1'b0,1'b0,1'b0,1'b0,64'h0000000ffff80000,64'h0,16'h0000,64'h0000000ffff7ffff},
    {3'd4,1'b1,1'b1,1'b0,1'b0,1'b0,64'h00ff00ff00ff0080,64'h0,16'h0000,64'h00ff00ff00ff0080},
    {3'd6,1'b0,1'b0,1'b1,1'b0,1'b0,64'h000000000000dead,64'h0,16'h0001,64'h0000000000010000},
    {3'd1,1'b0,1'b1,1'b0,1'b0,1'b0,64'h0000000000000010,64'h5,16'h0000,64'hfffffffffffffff5},
    {3'd7,1'b0,1'b0,1'b0,1'b0,1'b0,64'h0000000000000005,64'h0,16'h0010,64'h000000000000000b},
    {3'd5,1'b0,1'b0,1'b0,1'b0,1'b0,64'h0000000000000100,64'h0,16'hffff,64'h00000000000000ff},
    {3'd2,1'b0,1'b1,1'b0,1'b1,1'b0,64'h0000000000000001,64'h2,16'h0000,64'h0000000000000004},
    {3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,64'h000000007fffffff,64'h1,16'h0000,64'h0000000080000000},
    {3'd0,1'b1,1'b1,1'b0,1'b0,1'b0,64'h7fffffffffffffff,64'h1,16'h0000,64'h8000000000000000},
    {3'd1,1'b0,1'b1,1'b0,1'b0,1'b0,64'h0000000000001234,64'h1234,16'h0000,64'h0000000000000000},
    {3'd0,1'b0,1'b1,1'b0,1'b0,1'b1,64'h0000000000000001,64'h1,16'h0000,64'h0000000000000002},
    {3'd6,1'b0,1'b0,1'b0,1'b0,1'b0,64'h0000000000000001,64'h0,16'h8000,64'hffffffff80000001},
    {3'd3,1'b1,1'b0,1'b0,1'b0,1'b0,64'h8000000000000000,64'h0,16'h0000,64'h7fffffffffffffff},
    {3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,64'h7fffffffffffffff,64'h1,16'h0000,64'h8000000000000000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op_sel;
  logic        ov_en, rec_en, ra_zero, ca_in, so_in;
  logic [63:0] opnd_a, opnd_b;
  logic [15:0] imm;
  logic        out_valid, ca_we, ov_we, so_out, cr_we;
  logic [63:0] result;
  logic [1:0]  ca_out, ov_out;
  logic [3:0]  cr_out;

  int n_chk = 0;
  int n_bad = 0;

  // model outputs
  logic [63:0] m_res;
  logic [1:0]  m_ca, m_ov;
  logic        m_so, m_cawe, m_ovwe, m_crwe;
  logic [3:0]  m_cr;

  always #(CLK_P/2) clk = ~clk;

  int_addsub_unit u_int_addsub_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .ov_en(ov_en), .rec_en(rec_en), .ra_zero(ra_zero), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .imm(imm), .ca_in(ca_in), .so_in(so_in),
    .out_valid(out_valid), .result(result), .ca_out(ca_out), .ca_we(ca_we),
    .ov_out(ov_out), .ov_we(ov_we), .so_out(so_out), .cr_out(cr_out),
    .cr_we(cr_we)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected values from the requirements
  task automatic model(input logic [215:0] v);
    logic [2:0]  op;
    logic [63:0] ae, be, sx;
    logic        c, ov64, ov32, rg;
    logic [64:0] s;
    logic [32:0] s32;
    op = v[215:213];
    sx = {{48{v[79]}}, v[79:64]};
    c  = 1'b0;
    ae = v[207:144];
    be = v[143:80];
    case (op)
      3'd1: begin ae = ~v[207:144]; c = 1'b1; end
      3'd2: c = v[209];
      3'd3: begin be = '1; c = v[209]; end
      3'd4: begin be = '0; c = v[209]; end
      3'd5: begin ae = v[210] ? 64'd0 : v[207:144]; be = sx; end
      3'd6: begin ae = v[210] ? 64'd0 : v[207:144]; be = {sx[47:0], 16'h0000}; end
      3'd7: begin ae = ~v[207:144]; be = sx; c = 1'b1; end
      default: ;
    endcase
    s    = {1'b0, ae} + {1'b0, be} + {64'd0, c};
    s32  = {1'b0, ae[31:0]} + {1'b0, be[31:0]} + {32'd0, c};
    ov64 = (s[64] ^ s[63]) & ~(ae[63] ^ be[63]);
    ov32 = (s32[32] ^ s32[31]) & ~(ae[31] ^ be[31]);
    rg   = (op <= 3'd4);
    m_res  = s[63:0];
    m_cawe = (op == 3'd2) || (op == 3'd3) || (op == 3'd4) || (op == 3'd7);
    m_ovwe = v[212] && rg;
    m_crwe = v[211] && rg;
    m_ca   = m_cawe ? {s32[32], s[64]} : 2'b00;
    m_ov   = m_ovwe ? {ov32, ov64} : 2'b00;
    m_so   = v[208] | (m_ovwe & ov64);
    m_cr   = m_crwe ? {s[63], ~s[63] & (s[63:0] != 0), s[63:0] == 0, m_so} : 4'b0000;
  endtask

  task automatic drive(input logic [215:0] v);
    @(negedge clk);
    op_sel = v[215:213]; ov_en = v[212]; rec_en = v[211]; ra_zero = v[210];
    ca_in = v[209]; so_in = v[208]; opnd_a = v[207:144]; opnd_b = v[143:80];
    imm = v[79:64];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_sel = 3'd0; ov_en = 1'b0; rec_en = 1'b0;
    ra_zero = 1'b0; ca_in = 1'b0; so_in = 1'b0; opnd_a = '0; opnd_b = '0; imm = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 result", result, 64'd0);
    check("R9 flags", {59'd0, out_valid, ca_we, ov_we, cr_we, so_out},
          64'd0);
    check("R9 nibbles", {58'd0, ca_out, ov_out, cr_out[1:0]} | {62'd0, cr_out[3:2]}, 64'd0);
    rst_n = 1'b1;

    // table walk, R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      model(VEC[i]);
      check("R1/R2 model", m_res, VEC[i][63:0]);
      drive(VEC[i]);
      check("R8 valid", {63'd0, out_valid}, 64'd1);
      check("R1 R2 R3 result", result, VEC[i][63:0]);
      check("R4 carry", {61'd0, ca_we, ca_out}, {61'd0, m_cawe, m_ca});
      check("R5 overflow", {61'd0, ov_we, ov_out}, {61'd0, m_ovwe, m_ov});
      check("R6 summary", {63'd0, so_out}, {63'd0, m_so});
      check("R7 cond", {59'd0, cr_we, cr_out}, {59'd0, m_crwe, m_cr});
    end

    // R5 single-boundary overflow at 32 only (vector 13)
    drive(VEC[13]);
    check("R5 ov32 only", {62'd0, ov_out}, 64'd2);
    // R4 add-minus-one with carry-in 1 keeps A, both carries set
    drive(VEC[5]);
    check("R4 addm1 carries", {62'd0, ca_out}, 64'd3);
    // R6/R7 incoming summary copied to nibble bit 0
    drive(VEC[16]);
    check("R7 so into cr", {60'd0, cr_out}, 64'h5);

    // R3 ra_zero ignored on a register form
    drive({3'd0,1'b0,1'b0,1'b1,1'b0,1'b0,64'h5,64'h6,16'h0,64'hb});
    check("R3 ignored on ADD", result, 64'hb);

    // R8 hold: new inputs without in_valid must not change outputs
    @(negedge clk);
    opnd_a = 64'h1111; opnd_b = 64'h2222; op_sel = 3'd1; rec_en = 1'b1; so_in = 1'b1;
    @(negedge clk);
    check("R8 idle valid", {63'd0, out_valid}, 64'd0);
    check("R8 hold result", result, 64'hb);
    check("R8 hold flags", {58'd0, so_out, cr_we, cr_out}, 64'd0);

    // R9 asynchronous reset mid-run
    drive(VEC[0]);
    #1 rst_n = 1'b0;
    #1;
    check("R9 async clear", result, 64'd0);
    check("R9 async valid", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule